// File: doc/BRIEF.md
# Multi-Source Scoped Reset Controller

This block gathers five reset causes and turns them into one synchronous, active-high reset line for each of seven on-chip modules. The causes are a power-on pulse, an active-low board reset pin, a watchdog request, a request from the host-interface module, and a software request. Each cause reaches only its own subset of modules. A "hard" cause is power-on, the pin or the watchdog, and it reaches every module. The host-interface request spares the host interface and the memory controller. The software request also spares the processor.

A separate general-register reset covers the bus-speed setting, the bus-clock-gate setting and the three port registers. Only hard causes drive it, so those settings survive host-interface and software resets. After a hard reset ends, a counter keeps the processor's boot-fetch enable low for a fixed number of clocks. A sticky status register records which causes have occurred. Software clears its bits by writing ones.

Module index order on `modRst` is processor 0, Ethernet front end 1, DMA 2, host interface 3, general registers 4, memory controller 5, serial 6. Bit order of `causeStatus` and `causeClrData` is power-on 0, pin 1, watchdog 2, host interface 3, software 4.

Top module: `reset_scope_ctrl`

## Requirements
- R1: While `pwrOnRst` is high, `modRst` is 7'h7F and `genHoldRst` is 1, with no clock edge needed. `bootFetchEn` is 0 and `causeStatus` is 5'b00001.
- R2: The hard reset is released synchronously. `modRst` and `genHoldRst` stay asserted through the first rising edge after the last hard pin source goes inactive, and they drop on the second rising edge.
- R3: A one-cycle `wdogReq` pulse sets `modRst` to 7'h7F and `genHoldRst` to 1.
- R4: A one-cycle `eniReq` pulse sets `modRst` to 7'h57 (bits 0,1,2,4,6). Bits 3 and 5 stay 0, and `genHoldRst` stays 0.
- R5: A one-cycle `swReq` pulse sets `modRst` to 7'h56 (bits 1,2,4,6). `genHoldRst` stays 0, and `bootFetchEn` is unaffected.
- R6: Each watchdog, host-interface or software request pulse is stretched. The effect starts at the edge that samples the request and lasts exactly 8 clock cycles.
- R7: `bootFetchEn` goes high exactly 512 rising edges after a hard reset (power-on, pin or watchdog) is released. It is low for the whole reset.
- R8: A short low pulse on `extRstN` while the block is running asynchronously asserts every reset, including `genHoldRst`, and clears `bootFetchEn`. It then runs the full R2 and R7 release sequence.
- R9: Each cause sets its own `causeStatus` bit, and the bit stays set until it is cleared. Bit 1 is set by the pin, bit 2 by the watchdog, bit 3 by the host interface and bit 4 by software.
- R10: A cycle with `causeClrWe` high clears the status bits selected by ones in `causeClrData`. A cause event in that same cycle still sets its bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| pwrOnRst | input | 1 | Power-on reset pulse, active high, asynchronous |
| extRstN | input | 1 | Board reset pin, active low, asynchronous |
| wdogReq | input | 1 | Watchdog reset request, one-cycle pulse |
| eniReq | input | 1 | Host-interface reset request, one-cycle pulse |
| swReq | input | 1 | Software reset request, one-cycle pulse |
| causeClrWe | input | 1 | Write strobe for clearing cause bits |
| causeClrData | input | 5 | Ones select the cause bits to clear |
| modRst | output | 7 | Per-module active-high resets |
| genHoldRst | output | 1 | Hard-only reset for the retained general settings |
| bootFetchEn | output | 1 | Processor may start fetching at address 0 |
| causeStatus | output | 5 | Sticky reset-cause bits |

## Verification
A cause-clear write and a new reset event can land in the same cycle. To provoke it, the bench first sets the host-interface cause bit. It then drives `causeClrWe` with all ones at the same falling edge where it raises `swReq`. The result is judged at the next falling edge: only the software bit may remain. A second overlap is a watchdog request that lands after the fetch hold-off has already ended. That case is judged by `bootFetchEn` dropping one cycle later and then counting the full 512 edges again.

// File: rtl/rstscope_pkg.sv
package rstscope_pkg;

  localparam int NUM_MOD  = 7;
  localparam int NUM_SRC  = 5;
  localparam int NUM_SOFT = 3;

  // module positions on the reset vector
  localparam int M_CPU = 0;
  localparam int M_EFE = 1;
  localparam int M_DMA = 2;
  localparam int M_ENI = 3;
  localparam int M_GEN = 4;
  localparam int M_MEM = 5;
  localparam int M_SER = 6;

  // cause bit positions
  localparam int S_PWR  = 0;
  localparam int S_EXT  = 1;
  localparam int S_WDOG = 2;
  localparam int S_ENI  = 3;
  localparam int S_SW   = 4;

  // index of each pulse-type request inside the soft vectors
  localparam int Q_WDOG = 0;
  localparam int Q_ENI  = 1;
  localparam int Q_SW   = 2;

  typedef logic [NUM_MOD-1:0] modVec_t;

  // which modules a pulse-type request reaches
  function automatic modVec_t scopeMask(input int reqIdx);
    modVec_t m;
    m = '1;
    case (reqIdx)
      Q_ENI: begin
        m[M_ENI] = 1'b0;
        m[M_MEM] = 1'b0;
      end
      Q_SW: begin
        m[M_ENI] = 1'b0;
        m[M_MEM] = 1'b0;
        m[M_CPU] = 1'b0;
      end
      default: m = '1;
    endcase
    return m;
  endfunction

  // strobes from control to datapath
  typedef struct packed {
    logic                hardRst;    // synchronized pin-type hard reset
    logic [NUM_SOFT-1:0] reqActive;  // stretched request windows
    logic [NUM_SOFT-1:0] reqEvt;     // accepted request this cycle
    logic                extSeen;    // pin seen low after synchronization
  } rstStrobes_t;

endpackage

// File: rtl/rstscope_ctrl.sv
module rstscope_ctrl
  import rstscope_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STRETCH_LEN = 8,
  parameter int FETCH_HOLD  = 512
) (
  input  logic        clk,
  input  logic        pwrOnRst,
  input  logic        extRstN,
  input  logic        wdogReq,
  input  logic        eniReq,
  input  logic        swReq,
  output rstStrobes_t strobes,
  output logic        bootFetchEn
);

  localparam int SCW = $clog2(STRETCH_LEN + 1);
  localparam int FCW = $clog2(FETCH_HOLD + 1);
  localparam logic [SCW-1:0] STRETCH_V = SCW'(STRETCH_LEN);
  localparam logic [FCW-1:0] HOLD_V    = FCW'(FETCH_HOLD);

  logic hardAsync;
  logic [SYNC_STAGES-1:0] hardSync;
  logic [SYNC_STAGES-1:0] extSync;
  logic pinHard;
  logic hardAll;
  logic [NUM_SOFT-1:0] reqVec;
  logic [NUM_SOFT-1:0] reqActive;
  logic [NUM_SOFT-1:0] reqEvt;
  logic [FCW-1:0] fetchCnt;

  assign hardAsync = pwrOnRst | ~extRstN;

  // asynchronous assert, synchronous release of the pin-type hard reset
  always_ff @(posedge clk or posedge hardAsync) begin
    if (hardAsync) hardSync <= '1;
    else           hardSync <= {hardSync[SYNC_STAGES-2:0], 1'b0};
  end
  assign pinHard = hardSync[SYNC_STAGES-1];

  p_sync_release_r2: assert property (@(posedge clk) disable iff (pwrOnRst)
    $fell(pinHard) |-> !$past(hardAsync));

  // pin level brought into the clock domain for cause capture
  always_ff @(posedge clk or posedge pwrOnRst) begin
    if (pwrOnRst) extSync <= '0;
    else          extSync <= {extSync[SYNC_STAGES-2:0], ~extRstN};
  end

  assign reqVec = {swReq, eniReq, wdogReq};

  // one stretcher per pulse-type request
  for (genvar g = 0; g < NUM_SOFT; g++) begin : g_stretch
    logic [SCW-1:0] cnt;
    always_ff @(posedge clk or posedge pinHard) begin
      if (pinHard)               cnt <= '0;
      else if (reqVec[g])        cnt <= STRETCH_V;
      else if (cnt != '0)        cnt <= cnt - 1'b1;
    end
    assign reqActive[g] = (cnt != '0);
    assign reqEvt[g]    = reqVec[g] & ~pinHard;

    p_stretch_start_r6: assert property (@(posedge clk) disable iff (pwrOnRst || pinHard)
      $rose(reqActive[g]) |-> $past(reqVec[g]));
    p_stretch_hold_r6: assert property (@(posedge clk) disable iff (pwrOnRst || pinHard)
      reqVec[g] |=> reqActive[g]);
  end

  assign hardAll = pinHard | reqActive[Q_WDOG];

  // boot fetch hold-off after any hard reset
  always_ff @(posedge clk or posedge pinHard) begin
    if (pinHard)                  fetchCnt <= '0;
    else if (reqActive[Q_WDOG])   fetchCnt <= '0;
    else if (fetchCnt != HOLD_V)  fetchCnt <= fetchCnt + 1'b1;
  end
  assign bootFetchEn = (fetchCnt == HOLD_V);

  p_fetch_hold_r7: assert property (@(posedge clk) disable iff (pwrOnRst)
    hardAll |=> !bootFetchEn);

  always_comb begin
    strobes.hardRst   = pinHard;
    strobes.reqActive = reqActive;
    strobes.reqEvt    = reqEvt;
    strobes.extSeen   = extSync[SYNC_STAGES-1];
  end

endmodule

// File: rtl/rstscope_dp.sv
module rstscope_dp
  import rstscope_pkg::*;
(
  input  logic               clk,
  input  logic               pwrOnRst,
  input  rstStrobes_t        strobes,
  input  logic               causeClrWe,
  input  logic [NUM_SRC-1:0] causeClrData,
  output logic [NUM_MOD-1:0] modRst,
  output logic               genHoldRst,
  output logic [NUM_SRC-1:0] causeStatus
);

  localparam modVec_t WDOG_MASK = scopeMask(Q_WDOG);
  localparam modVec_t ENI_MASK  = scopeMask(Q_ENI);
  localparam modVec_t SW_MASK   = scopeMask(Q_SW);

  logic [NUM_SRC-1:0] setVec;
  logic [NUM_SRC-1:0] clrVec;

  // per-module reset fan-in
  for (genvar m = 0; m < NUM_MOD; m++) begin : g_mod
    assign modRst[m] = strobes.hardRst
                     | (strobes.reqActive[Q_WDOG] & WDOG_MASK[m])
                     | (strobes.reqActive[Q_ENI]  & ENI_MASK[m])
                     | (strobes.reqActive[Q_SW]   & SW_MASK[m]);
  end

  // retained general settings: hard causes only
  assign genHoldRst = strobes.hardRst | strobes.reqActive[Q_WDOG];

  p_hard_all_r3: assert property (@(posedge clk) disable iff (pwrOnRst)
    strobes.reqActive[Q_WDOG] |-> (&modRst) && genHoldRst);
  p_eni_scope_r4: assert property (@(posedge clk) disable iff (pwrOnRst)
    strobes.reqActive[Q_ENI] && !genHoldRst |-> !modRst[M_ENI] && !modRst[M_MEM] && modRst[M_CPU]);
  p_sw_scope_r5: assert property (@(posedge clk) disable iff (pwrOnRst)
    strobes.reqActive[Q_SW] && !strobes.reqActive[Q_ENI] && !genHoldRst |-> !modRst[M_CPU]);

  // sticky cause register, set dominates clear
  always_comb begin
    setVec          = '0;
    setVec[S_EXT]   = strobes.extSeen;
    setVec[S_WDOG]  = strobes.reqEvt[Q_WDOG];
    setVec[S_ENI]   = strobes.reqEvt[Q_ENI];
    setVec[S_SW]    = strobes.reqEvt[Q_SW];
    clrVec          = causeClrWe ? causeClrData : '0;
  end

  always_ff @(posedge clk or posedge pwrOnRst) begin
    if (pwrOnRst) causeStatus <= NUM_SRC'(1) << S_PWR;
    else          causeStatus <= (causeStatus & ~clrVec) | setVec;
  end

  p_cause_sticky_r9: assert property (@(posedge clk) disable iff (pwrOnRst)
    !causeClrWe |=> (($past(causeStatus) & ~causeStatus) == '0));
  p_set_wins_r10: assert property (@(posedge clk) disable iff (pwrOnRst)
    causeClrWe && strobes.reqEvt[Q_SW] |=> causeStatus[S_SW]);

endmodule

// File: rtl/reset_scope_ctrl.sv
module reset_scope_ctrl
  import rstscope_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STRETCH_LEN = 8,
  parameter int FETCH_HOLD  = 512
) (
  input  logic               clk,
  input  logic               pwrOnRst,
  input  logic               extRstN,
  input  logic               wdogReq,
  input  logic               eniReq,
  input  logic               swReq,
  input  logic               causeClrWe,
  input  logic [NUM_SRC-1:0] causeClrData,
  output logic [NUM_MOD-1:0] modRst,
  output logic               genHoldRst,
  output logic               bootFetchEn,
  output logic [NUM_SRC-1:0] causeStatus
);

  rstStrobes_t strobes;

  rstscope_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .STRETCH_LEN(STRETCH_LEN),
    .FETCH_HOLD (FETCH_HOLD)
  ) u_ctrl (
    .clk        (clk),
    .pwrOnRst   (pwrOnRst),
    .extRstN    (extRstN),
    .wdogReq    (wdogReq),
    .eniReq     (eniReq),
    .swReq      (swReq),
    .strobes    (strobes),
    .bootFetchEn(bootFetchEn)
  );

  rstscope_dp u_dp (
    .clk         (clk),
    .pwrOnRst    (pwrOnRst),
    .strobes     (strobes),
    .causeClrWe  (causeClrWe),
    .causeClrData(causeClrData),
    .modRst      (modRst),
    .genHoldRst  (genHoldRst),
    .causeStatus (causeStatus)
  );

endmodule

// File: tb/tb_reset_scope_ctrl.sv
module tb_reset_scope_ctrl;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       pwrOnRst;
  logic       extRstN;
  logic       wdogReq;
  logic       eniReq;
  logic       swReq;
  logic       causeClrWe;
  logic [4:0] causeClrData;
  logic [6:0] modRst;
  logic       genHoldRst;
  logic       bootFetchEn;
  logic [4:0] causeStatus;

  int nChecks = 0;
  int nErr    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reset_scope_ctrl dut (
    .clk(clk), .pwrOnRst(pwrOnRst), .extRstN(extRstN), .wdogReq(wdogReq),
    .eniReq(eniReq), .swReq(swReq), .causeClrWe(causeClrWe),
    .causeClrData(causeClrData), .modRst(modRst), .genHoldRst(genHoldRst),
    .bootFetchEn(bootFetchEn), .causeStatus(causeStatus)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // called at the falling edge where the hard reset is first seen released
  task automatic holdoff(input string req);
    repeat (511) @(negedge clk);
    check(req, "fetch low at edge 511", 32'(bootFetchEn), 32'd0);
    @(negedge clk);
    check(req, "fetch high at edge 512", 32'(bootFetchEn), 32'd1);
  endtask

  task automatic clearAll();
    @(negedge clk);
    causeClrWe   = 1'b1;
    causeClrData = 5'h1F;
    @(negedge clk);
    causeClrWe   = 1'b0;
    causeClrData = 5'h00;
    check("R10", "cause cleared", 32'(causeStatus), 32'd0);
  endtask

  task automatic t_powerup();
    repeat (3) @(negedge clk);
    check("R1", "modRst in power-up", 32'(modRst), 32'h7F);
    check("R1", "genHold in power-up", 32'(genHoldRst), 32'd1);
    check("R1", "fetch in power-up", 32'(bootFetchEn), 32'd0);
    check("R1", "cause in power-up", 32'(causeStatus), 32'h01);
    pwrOnRst = 1'b0;
    @(negedge clk);
    check("R2", "still held after one edge", 32'(modRst), 32'h7F);
    @(negedge clk);
    check("R2", "released after two edges", 32'(modRst), 32'h00);
    check("R2", "genHold released", 32'(genHoldRst), 32'd0);
    holdoff("R7");
  endtask

  task automatic t_soft(input string req, input bit isEni,
                        input logic [6:0] mask, input logic [4:0] cause);
    @(negedge clk);
    if (isEni) eniReq = 1'b1; else swReq = 1'b1;
    @(negedge clk);
    eniReq = 1'b0;
    swReq  = 1'b0;
    check(req, "scoped resets", 32'(modRst), 32'(mask));
    check(req, "genHold untouched", 32'(genHoldRst), 32'd0);
    check(req, "fetch kept", 32'(bootFetchEn), 32'd1);
    check("R9", "cause bit", 32'(causeStatus), 32'(cause));
    repeat (7) @(negedge clk);
    check("R6", "still stretched at cycle 8", 32'(modRst), 32'(mask));
    @(negedge clk);
    check("R6", "ended after 8 cycles", 32'(modRst), 32'h00);
    clearAll();
  endtask

  task automatic t_setwins();
    @(negedge clk);
    eniReq = 1'b1;
    @(negedge clk);
    eniReq = 1'b0;
    repeat (9) @(negedge clk);
    check("R9", "eni bit before overlap", 32'(causeStatus), 32'h08);
    swReq        = 1'b1;
    causeClrWe   = 1'b1;
    causeClrData = 5'h1F;
    @(negedge clk);
    swReq        = 1'b0;
    causeClrWe   = 1'b0;
    causeClrData = 5'h00;
    check("R10", "set beats clear", 32'(causeStatus), 32'h10);
    repeat (9) @(negedge clk);
    clearAll();
  endtask

  task automatic t_wdog();
    @(negedge clk);
    wdogReq = 1'b1;
    @(negedge clk);
    wdogReq = 1'b0;
    check("R3", "all modules", 32'(modRst), 32'h7F);
    check("R3", "genHold", 32'(genHoldRst), 32'd1);
    check("R9", "watchdog cause", 32'(causeStatus), 32'h04);
    @(negedge clk);
    check("R7", "fetch dropped", 32'(bootFetchEn), 32'd0);
    repeat (6) @(negedge clk);
    check("R6", "watchdog cycle 8", 32'(modRst), 32'h7F);
    @(negedge clk);
    check("R6", "watchdog ended", 32'(modRst), 32'h00);
    holdoff("R7");
    clearAll();
  endtask

  task automatic t_ext();
    @(negedge clk);
    extRstN = 1'b0;
    #1;
    check("R8", "async assert", 32'(modRst), 32'h7F);
    check("R8", "genHold async", 32'(genHoldRst), 32'd1);
    check("R8", "fetch cleared", 32'(bootFetchEn), 32'd0);
    repeat (3) @(negedge clk);
    extRstN = 1'b1;
    @(negedge clk);
    check("R2", "pin release first edge", 32'(modRst), 32'h7F);
    @(negedge clk);
    check("R2", "pin release second edge", 32'(modRst), 32'h00);
    check("R9", "pin cause", 32'(causeStatus), 32'h02);
    holdoff("R8");
    clearAll();
  endtask

  initial begin
    pwrOnRst = 1'b1; extRstN = 1'b1; wdogReq = 1'b0; eniReq = 1'b0;
    swReq = 1'b0; causeClrWe = 1'b0; causeClrData = 5'h00;
    t_powerup();
    clearAll();
    t_soft("R4", 1'b1, 7'h57, 5'h08);
    t_soft("R5", 1'b0, 7'h56, 5'h10);
    t_setwins();
    t_wdog();
    t_ext();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    nChecks++;
    nErr++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule